// File: doc/BRIEF.md
# Multi-lane Hamming-similarity match scanner

The block stores a table of binary hashes and finds the stored hash that agrees best with a query hash. The match is not exact. Each stored row is scored by the number of bit positions where it equals the query, which is the popcount of the XNOR of the two. The row with the highest score is reported together with its index and score.

Rows are loaded one at a time through a row-addressed write port. Each row carries a valid flag that is set by its first write and cleared by reset. A query is offered on a valid/ready stream input. Once a query is accepted, the block latches it and scans the table `LANES` rows per cycle. It keeps a running best as it goes. When the scan ends, it raises a level-type result flag. The block accepts no new query while a scan is in progress. A query accepted at the same edge as its valid clears the previous result.

An optional noise mask can be XORed into the query as it is accepted, so that bit flips can be injected. A debug port shows the per-lane scores of each scan step as they are computed.

Back-pressure rules:
- `query_ready` is high whenever no scan is running, and a query transfers on any rising edge where `query_valid` and `query_ready` are both high.
- While a scan runs, `query_ready` is low and the query inputs are ignored.
- The result has no ready of its own. It stays valid until the next query transfers.

Top module: `hsim_scanner`

## Requirements
- R1: The score of a row is the count of bit positions, over all `HASH_BITS`, where the stored row equals the effective query: popcount(~(row ^ query)).
- R2: At the end of a scan, `best_idx` and `best_score` give the highest-scoring written row, and `result_hit` is 1 if at least one row is written.
- R3: On equal scores the lower row index wins. This holds both among the lanes of one step and across steps.
- R4: Rows never written since reset are skipped. If no row is written, the result has `result_hit`=0, `best_idx`=0 and `best_score`=0.
- R5: `result_valid` rises exactly `NUM_ROWS/LANES` rising edges after the edge that accepts the query, and `query_ready` is low from the edge after acceptance until that point.
- R6: The query and noise inputs are sampled only at the accepting edge. `query_valid`, `query_hash`, `noise_en` and `noise_mask` have no effect while `query_ready` is low.
- R7: Once `result_valid` is high, it stays high and the result stays unchanged until a new query is accepted. `result_valid` then drops at that accepting edge.
- R8: If `noise_en` is 1 at the accepting edge, the effective query is `query_hash ^ noise_mask`: a mask bit of 1 flips that query bit. Otherwise the effective query is `query_hash`.
- R9: In scan step k (k from 0), `dbg_valid`=1 and `dbg_base`=k*LANES. Lane l of `dbg_lane_ok` is the written flag of row `dbg_base`+l. Lane l of `dbg_scores`, at bits [l*SCORE_W +: SCORE_W], holds that row's R1 score, or 0 if the row is unwritten. Outside a scan, `dbg_valid`=0.
- R10: A synchronous active-high `rst` clears all row-written flags, stops any scan, and clears `result_valid`. After reset, `query_ready`=1.
- R11: A write with `wr_en`=1 stores `wr_data` at `wr_addr` on the rising edge and marks the row written. A later write to the same address replaces the content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | IDX_W | Row to write |
| wr_data | input | HASH_BITS | Hash to store |
| query_valid | input | 1 | Query offered |
| query_ready | output | 1 | Block can accept a query |
| query_hash | input | HASH_BITS | Query hash |
| noise_en | input | 1 | Apply the noise mask to this query |
| noise_mask | input | HASH_BITS | Bits to flip in the query |
| result_valid | output | 1 | Result is available and held |
| result_hit | output | 1 | At least one written row was scored |
| best_idx | output | IDX_W | Index of the best row |
| best_score | output | SCORE_W | Score of the best row |
| dbg_valid | output | 1 | A scan step is active |
| dbg_base | output | IDX_W | First row of the current step |
| dbg_lane_ok | output | LANES | Per-lane written flag |
| dbg_scores | output | LANES*SCORE_W | Per-lane scores, lane 0 in the low bits |

## Verification
The debug outputs of step k are combinational from the step counter, so they are valid during the k-th cycle after the accepting edge. The bench compares them at the falling edge of that cycle. `result_valid` and the result registers update on the `NUM_ROWS/LANES`-th edge after acceptance. At every falling edge in between, the bench requires `result_valid` and `query_ready` to be low, and it checks the full result at the first falling edge after that. During the scan, the bench drives a conflicting query, so R6 shows in the result. It also samples the result again a few cycles later, before it offers the next query, to check that the result is held.

// File: rtl/hsim_pkg.sv
package hsim_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/hsim_popcount.sv
module hsim_popcount #(
  parameter int W = 512,
  parameter int GROUP = 8
) (
  input  logic [W-1:0]           vec,
  output logic [$clog2(W+1)-1:0] count
);
  localparam int NG = (W + GROUP - 1) / GROUP;
  localparam int PW = NG * GROUP;
  localparam int GW = $clog2(GROUP + 1);
  localparam int CW = $clog2(W + 1);

  logic [PW-1:0] padded;
  logic [GW-1:0] grp_cnt [NG];

  assign padded = PW'(vec);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_comb begin
      grp_cnt[g] = '0;
      for (int b = 0; b < GROUP; b++) begin
        grp_cnt[g] = grp_cnt[g] + GW'(padded[g*GROUP + b]);
      end
    end
  end

  always_comb begin
    count = '0;
    for (int g = 0; g < NG; g++) begin
      count = count + CW'(grp_cnt[g]);
    end
  end
endmodule

// File: rtl/hsim_row_store.sv
module hsim_row_store #(
  parameter int ROWS = 512,
  parameter int BITS = 512,
  parameter int LANES = 16,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_addr,
  input  logic [BITS-1:0]             wr_data,
  input  logic [LANES-1:0][IDX_W-1:0] rd_addr,
  output logic [LANES-1:0][BITS-1:0]  rd_data,
  output logic [LANES-1:0]            rd_ok
);
  logic [BITS-1:0] mem [ROWS];
  logic [ROWS-1:0] row_ok;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) row_ok <= '0;
    else if (wr_en) row_ok[wr_addr] <= 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_data[l] = mem[rd_addr[l]];
    assign rd_ok[l]   = row_ok[rd_addr[l]];
  end

  // R11
  wr_marks_row_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> row_ok[$past(wr_addr)]);
endmodule

// File: rtl/hsim_argmax.sv
module hsim_argmax #(
  parameter int LANES = 16,
  parameter int IDX_W = 9,
  parameter int SCORE_W = 10,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          step_en,
  input  logic [IDX_W-1:0]              base,
  input  logic [LANES-1:0]              lane_ok,
  input  logic [LANES-1:0][SCORE_W-1:0] lane_score,
  output logic                          best_found,
  output logic [IDX_W-1:0]              best_idx,
  output logic [SCORE_W-1:0]            best_score
);
  logic               sb_ok;
  logic [LW-1:0]      sb_lane;
  logic [SCORE_W-1:0] sb_score;

  // lane 0 is scanned first; strict compare keeps the lower lane on a tie
  always_comb begin
    sb_ok    = 1'b0;
    sb_lane  = '0;
    sb_score = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_ok[l] && (!sb_ok || lane_score[l] > sb_score)) begin
        sb_ok    = 1'b1;
        sb_lane  = LW'(l);
        sb_score = lane_score[l];
      end
    end
  end

  // earlier steps hold lower rows; strict compare keeps them on a tie
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      best_found <= 1'b0;
      best_idx   <= '0;
      best_score <= '0;
    end else if (step_en && sb_ok && (!best_found || sb_score > best_score)) begin
      best_found <= 1'b1;
      best_idx   <= base + IDX_W'(sb_lane);
      best_score <= sb_score;
    end
  end

  // R2
  best_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (best_found && !clear) |=> (best_found && best_score >= $past(best_score)));
endmodule

// File: rtl/hsim_scanner.sv
module hsim_scanner #(
  parameter int NUM_ROWS = 512,
  parameter int HASH_BITS = 512,
  parameter int LANES = 16,
  parameter int GROUP_BITS = 8,
  localparam int IDX_W = $clog2(NUM_ROWS),
  localparam int SCORE_W = $clog2(HASH_BITS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_addr,
  input  logic [HASH_BITS-1:0]       wr_data,
  input  logic                       query_valid,
  output logic                       query_ready,
  input  logic [HASH_BITS-1:0]       query_hash,
  input  logic                       noise_en,
  input  logic [HASH_BITS-1:0]       noise_mask,
  output logic                       result_valid,
  output logic                       result_hit,
  output logic [IDX_W-1:0]           best_idx,
  output logic [SCORE_W-1:0]         best_score,
  output logic                       dbg_valid,
  output logic [IDX_W-1:0]           dbg_base,
  output logic [LANES-1:0]           dbg_lane_ok,
  output logic [LANES*SCORE_W-1:0]   dbg_scores
);
  import hsim_pkg::*;

  localparam int STEPS  = NUM_ROWS / LANES;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  scan_state_t          state_q;
  logic [STEP_W-1:0]    step_q;
  logic [HASH_BITS-1:0] query_q;
  logic                 scanning, accept, last_step;
  logic [IDX_W-1:0]     base;

  logic [LANES-1:0][IDX_W-1:0]     rd_addr;
  logic [LANES-1:0][HASH_BITS-1:0] rd_data;
  logic [LANES-1:0]                rd_ok;
  logic [LANES-1:0][SCORE_W-1:0]   raw_score;
  logic [LANES-1:0][SCORE_W-1:0]   lane_score;

  assign scanning    = (state_q == ST_SCAN);
  assign query_ready = !scanning;
  assign accept      = query_valid && query_ready;
  assign last_step   = (step_q == STEP_W'(STEPS - 1));
  assign base        = IDX_W'(32'(step_q) * LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      query_q      <= '0;
      result_valid <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            query_q      <= noise_en ? (query_hash ^ noise_mask) : query_hash;
            step_q       <= '0;
            result_valid <= 1'b0;
            state_q      <= ST_SCAN;
          end
        end
        default: begin
          if (last_step) begin
            state_q      <= ST_IDLE;
            result_valid <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
      endcase
    end
  end

  hsim_row_store #(
    .ROWS (NUM_ROWS),
    .BITS (HASH_BITS),
    .LANES(LANES)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .rd_ok  (rd_ok)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_addr[l] = base + IDX_W'(l);

    hsim_popcount #(
      .W    (HASH_BITS),
      .GROUP(GROUP_BITS)
    ) u_pop (
      .vec  (~(rd_data[l] ^ query_q)),
      .count(raw_score[l])
    );

    assign lane_score[l] = rd_ok[l] ? raw_score[l] : '0;
    assign dbg_scores[l*SCORE_W +: SCORE_W] = lane_score[l];
  end

  hsim_argmax #(
    .LANES  (LANES),
    .IDX_W  (IDX_W),
    .SCORE_W(SCORE_W)
  ) u_best (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .step_en   (scanning),
    .base      (base),
    .lane_ok   (rd_ok),
    .lane_score(lane_score),
    .best_found(result_hit),
    .best_idx  (best_idx),
    .best_score(best_score)
  );

  assign dbg_valid   = scanning;
  assign dbg_base    = base;
  assign dbg_lane_ok = rd_ok;

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !query_ready);

  // R5
  done_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(result_valid) |-> $past(scanning && last_step));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !accept) |=> (result_valid && $stable(best_idx) && $stable(best_score) && $stable(result_hit)));
endmodule

// File: tb/hsim_scanner_test.sv
`timescale 1ns/1ps
module hsim_scanner_test;
  localparam int ROWS = 32;
  localparam int BITS = 44;
  localparam int LN = 4;
  localparam int STEPS = ROWS / LN;
  localparam int IW = $clog2(ROWS);
  localparam int SW = $clog2(BITS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_addr = '0;
  logic [BITS-1:0] wr_data = '0;
  logic query_valid = 1'b0;
  logic query_ready;
  logic [BITS-1:0] query_hash = '0;
  logic noise_en = 1'b0;
  logic [BITS-1:0] noise_mask = '0;
  logic result_valid, result_hit;
  logic [IW-1:0] best_idx;
  logic [SW-1:0] best_score;
  logic dbg_valid;
  logic [IW-1:0] dbg_base;
  logic [LN-1:0] dbg_lane_ok;
  logic [LN*SW-1:0] dbg_scores;

  always #2 clk = ~clk;

  hsim_scanner #(.NUM_ROWS(ROWS), .HASH_BITS(BITS), .LANES(LN)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .query_valid(query_valid), .query_ready(query_ready), .query_hash(query_hash),
    .noise_en(noise_en), .noise_mask(noise_mask), .result_valid(result_valid),
    .result_hit(result_hit), .best_idx(best_idx), .best_score(best_score),
    .dbg_valid(dbg_valid), .dbg_base(dbg_base), .dbg_lane_ok(dbg_lane_ok),
    .dbg_scores(dbg_scores));

  logic [BITS-1:0] m_row [ROWS];
  logic m_ok [ROWS];
  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int score_of(input logic [BITS-1:0] r, input logic [BITS-1:0] q);
    return $countones(~(r ^ q));
  endfunction

  function automatic logic [BITS-1:0] rnd_hash();
    return BITS'({$urandom, $urandom});
  endfunction

  task automatic wr_row(input int a, input logic [BITS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_row[a] = d; m_ok[a] = 1'b1;
  endtask

  task automatic run_query(input logic [BITS-1:0] q, input bit nen, input logic [BITS-1:0] nm);
    logic [BITS-1:0] eq;
    int e_idx, e_sc;
    bit e_hit;
    eq = nen ? (q ^ nm) : q;
    e_hit = 0; e_idx = 0; e_sc = 0;
    for (int r = 0; r < ROWS; r++) begin
      if (m_ok[r] && (!e_hit || score_of(m_row[r], eq) > e_sc)) begin
        e_hit = 1; e_idx = r; e_sc = score_of(m_row[r], eq);
      end
    end
    @(negedge clk);
    query_valid = 1'b1; query_hash = q; noise_en = nen; noise_mask = nm;
    for (int k = 0; k < STEPS; k++) begin
      @(negedge clk);
      // R5: busy, no result yet
      check(!query_ready && !result_valid, "R5 busy during scan", {query_ready, result_valid}, 0);
      // R9: debug view of step k
      check(dbg_valid && dbg_base == IW'(k * LN), "R9 dbg_base", dbg_base, k * LN);
      for (int l = 0; l < LN; l++) begin
        int r = k * LN + l;
        int es = m_ok[r] ? score_of(m_row[r], eq) : 0;
        check(dbg_lane_ok[l] == m_ok[r], "R9 dbg_lane_ok", dbg_lane_ok[l], m_ok[r]);
        check(int'(dbg_scores[l*SW +: SW]) == es, "R1/R9 lane score", dbg_scores[l*SW +: SW], es);
      end
      // R6: conflicting inputs while busy must be ignored
      query_valid = 1'b1; query_hash = rnd_hash(); noise_en = $urandom_range(0, 1); noise_mask = rnd_hash();
    end
    @(negedge clk);
    query_valid = 1'b0;
    check(result_valid && query_ready, "R5 result after NUM_ROWS/LANES edges", result_valid, 1);
    check(result_hit == e_hit, "R2/R4 result_hit", result_hit, e_hit);
    check(int'(best_idx) == e_idx, "R2/R3/R6 best_idx", best_idx, e_idx);
    check(int'(best_score) == e_sc, "R1/R2/R8 best_score", best_score, e_sc);
    repeat (3) @(negedge clk);
    check(result_valid && int'(best_idx) == e_idx && int'(best_score) == e_sc,
          "R7 result held", best_idx, e_idx);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [BITS-1:0] h;
    void'($urandom(32'd1234));
    for (int r = 0; r < ROWS; r++) begin m_row[r] = '0; m_ok[r] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(query_ready && !result_valid && !dbg_valid, "R10 reset state", {query_ready, result_valid, dbg_valid}, 4);

    // R4: empty table
    run_query(rnd_hash(), 0, '0);

    // R11/R1: single row, exact match scores BITS
    h = rnd_hash();
    wr_row(9, h);
    run_query(h, 0, '0);
    check(int'(best_score) == BITS && best_idx == 9, "R1 exact match score", best_score, BITS);
    // R11: overwrite row 9 with the complement -> score 0
    wr_row(9, ~h);
    run_query(h, 0, '0);

    // R3: ties within a step (rows 6,7) and across steps (row 21)
    h = rnd_hash();
    wr_row(21, h); wr_row(7, h); wr_row(6, h);
    run_query(h, 0, '0);
    check(best_idx == 6, "R3 lower index wins", best_idx, 6);

    // R8: noise flips 5 bits of an exact match
    run_query(h, 1, BITS'(44'h1F));
    check(int'(best_score) == BITS - 5, "R8 noise flips", best_score, BITS - 5);

    // random fill and queries
    for (int r = 0; r < ROWS; r++) begin
      if ($urandom_range(0, 3) != 0) wr_row(r, rnd_hash());
    end
    for (int n = 0; n < 12; n++) begin
      bit ne = $urandom_range(0, 1);
      h = ($urandom_range(0, 1) == 1) ? m_row[$urandom_range(0, ROWS - 1)] : rnd_hash();
      run_query(h, ne, rnd_hash() & rnd_hash() & rnd_hash());
    end

    // R10: reset clears written flags
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < ROWS; r++) m_ok[r] = 1'b0;
    check(query_ready && !result_valid, "R10 reset clears result", result_valid, 0);
    run_query(rnd_hash(), 0, '0);
    check(!result_hit, "R4/R10 no rows after reset", result_hit, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule